// File: doc/BRIEF.md
# Pattern Instruction Fetch and Decode Stage

This block is the front stage of a two-stage pattern-matching pipeline. It reads fixed-format pattern instructions from a synchronous instruction memory. It splits each instruction into its fields and presents them, registered, to the execute stage that holds the comparators. Each instruction is an opcode followed by a reference field of pattern characters. The opcode carries an open-bracket flag, an internal operator that says how the reference characters are combined, and an external operator that describes the loop or bracket close that follows.

A run begins with a start pulse that carries the address of the first pattern instruction. That instruction is fetched once and copied into a backup buffer. While the pattern is matching, the memory output register always holds the next sequential instruction. A match report from the execute stage therefore issues the next instruction on the following cycle. A failure report reissues the backup copy on the following cycle. Neither path inserts an empty cycle. The memory address is steered in the same cycle as the feedback, so the prefetch of the instruction after the new one starts at once.

Top module: `regex_fd_stage`

## Requirements
- R1: After reset, dec_valid_o is 0 and imem_addr_o is 0 until the first start pulse.
- R2: In a cycle with start_i high, imem_addr_o equals start_addr_i. In the next cycle, dec_valid_o is 0 and imem_addr_o is start_addr_i+1. In the cycle after that, dec_valid_o is 1, dec_pc_o is the start address, and the fields show the instruction stored there.
- R3: Field layout of an instruction word of 37 bits: bit 36 is the open-bracket flag, bits 35:34 are the internal operator, bits 33:32 are the external operator, and bits 31:0 are the reference. Character i of the reference sits at bits 8i+7:8i.
- R4: dec_end_o is 1 exactly when the issued internal operator is 2'b11 (end of pattern). Code 2'b00 is all-characters-in-order and 2'b01 is any-one-character.
- R5: While running, the cycle after ex_match_i issues the instruction at dec_pc_o+1 with dec_valid_o held at 1. From then on, with no feedback, imem_addr_o is dec_pc_o+1.
- R6: A match reported on every cycle advances by one instruction per cycle, and the address wraps modulo 2^ADDR_W.
- R7: While running, the cycle after ex_fail_i issues the backup instruction at the start address with dec_valid_o held at 1, and imem_addr_o becomes the start address plus one.
- R8: When ex_fail_i and ex_match_i are both high, the fail takes effect.
- R9: With no feedback, the issued fields, dec_pc_o and imem_addr_o all hold.
- R10: A start pulse while running drops dec_valid_o on the next cycle and reloads from the new address.
- R11: Match and fail feedback in the loading cycle has no effect: the first issued instruction is still the one at the start address.
- R12: The backup is a copy taken at load. After the memory word at the start address changes, a fail still issues the originally loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart a pattern run |
| start_addr_i | input | ADDR_W | Address of the first pattern instruction |
| ex_match_i | input | 1 | Execute stage: issued instruction matched |
| ex_fail_i | input | 1 | Execute stage: partial match failed |
| imem_addr_o | output | ADDR_W | Instruction memory read address |
| imem_data_i | input | INSTR_W | Instruction memory read data, one cycle after the address |
| dec_valid_o | output | 1 | Issued fields are valid |
| dec_pc_o | output | ADDR_W | Address of the issued instruction |
| dec_open_o | output | 1 | Open-bracket flag |
| dec_int_op_o | output | 2 | Internal operator |
| dec_ext_op_o | output | 2 | External operator |
| dec_end_o | output | 1 | Internal operator is end of pattern |
| dec_ref_o | output | REF_W | Reference characters |

## Verification
The hardest case to reach from the ports is a fail that has to return a backup word that no longer matches memory. The bench loads a run, then rewrites the memory word at the start address. It advances one instruction and then reports a fail, so only the stored copy can give the expected word. A second difficult case is feedback that arrives during the loading cycle, or match and fail asserted together. The driver raises these while the start sequence is in flight, and raises both on an instruction other than the backup so that the outcome is visible.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  localparam int OPC_W = 5;

  localparam logic [1:0] INT_AND = 2'b00;
  localparam logic [1:0] INT_OR  = 2'b01;
  localparam logic [1:0] INT_NOP = 2'b11;

  localparam logic [1:0] EXT_NONE  = 2'b00;
  localparam logic [1:0] EXT_STAR  = 2'b01;
  localparam logic [1:0] EXT_PLUS  = 2'b10;
  localparam logic [1:0] EXT_CLOSE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOAD = 2'b01,
    ST_RUN  = 2'b10
  } fd_state_e;
endpackage

// File: rtl/rfd_decode.sv
module rfd_decode #(
  parameter int CHAR_W = 8,
  parameter int REF_N  = 4,
  localparam int REF_W   = CHAR_W * REF_N,
  localparam int INSTR_W = rfd_pkg::OPC_W + REF_W
) (
  input  logic [INSTR_W-1:0] word_i,
  output logic               open_o,
  output logic [1:0]         int_op_o,
  output logic [1:0]         ext_op_o,
  output logic               end_o,
  output logic [REF_W-1:0]   ref_o
);
  import rfd_pkg::*;

  logic [OPC_W-1:0] opc;

  assign opc      = word_i[INSTR_W-1 -: OPC_W];
  assign open_o   = opc[OPC_W-1];
  assign int_op_o = opc[OPC_W-2 -: 2];
  assign ext_op_o = opc[1:0];
  assign end_o    = (opc[OPC_W-2 -: 2] == INT_NOP);

  for (genvar c = 0; c < REF_N; c++) begin : g_chr
    assign ref_o[c*CHAR_W +: CHAR_W] = word_i[c*CHAR_W +: CHAR_W];
  end
endmodule

// File: rtl/rfd_ibuf.sv
module rfd_ibuf #(
  parameter int INSTR_W = 37
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_bak_i,
  input  logic               src_bak_i,
  input  logic [INSTR_W-1:0] pf_word_i,
  output logic [INSTR_W-1:0] sel_word_o
);
  logic [INSTR_W-1:0] bak_q;

  // backup copy of the first pattern instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         bak_q <= '0;
    else if (load_bak_i) bak_q <= pf_word_i;
  end

  // prefetch buffer is the memory output register
  assign sel_word_o = src_bak_i ? bak_q : pf_word_i;
endmodule

// File: rtl/rfd_ctl.sv
module rfd_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              match_i,
  input  logic              fail_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              issue_o,
  output logic              src_bak_o,
  output logic              load_bak_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] pc_o
);
  import rfd_pkg::*;

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  fd_state_e         st_q, st_d;
  logic [ADDR_W-1:0] bak_pc_q, bak_pc_d;
  logic [ADDR_W-1:0] cur_pc_q, cur_pc_d;
  logic              vld_q, vld_d;

  always_comb begin
    st_d       = st_q;
    bak_pc_d   = bak_pc_q;
    cur_pc_d   = cur_pc_q;
    vld_d      = vld_q;
    issue_o    = 1'b0;
    src_bak_o  = 1'b0;
    load_bak_o = 1'b0;
    addr_o     = cur_pc_q + ONE;
    if (start_i) begin
      st_d     = ST_LOAD;
      bak_pc_d = start_addr_i;
      vld_d    = 1'b0;
      addr_o   = start_addr_i;
    end else begin
      unique case (st_q)
        ST_LOAD: begin
          st_d       = ST_RUN;
          load_bak_o = 1'b1;
          issue_o    = 1'b1;
          cur_pc_d   = bak_pc_q;
          vld_d      = 1'b1;
          addr_o     = bak_pc_q + ONE;
        end
        ST_RUN: begin
          if (fail_i) begin
            issue_o   = 1'b1;
            src_bak_o = 1'b1;
            cur_pc_d  = bak_pc_q;
            addr_o    = bak_pc_q + ONE;
          end else if (match_i) begin
            issue_o  = 1'b1;
            cur_pc_d = cur_pc_q + ONE;
            addr_o   = cur_pc_q + TWO;
          end
        end
        default: addr_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bak_pc_q <= '0;
      cur_pc_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      bak_pc_q <= bak_pc_d;
      cur_pc_q <= cur_pc_d;
      vld_q    <= vld_d;
    end
  end

  assign valid_o = vld_q;
  assign pc_o    = cur_pc_q;
endmodule

// File: rtl/regex_fd_stage.sv
module regex_fd_stage #(
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 8,
  parameter int REF_N  = 4,
  localparam int REF_W   = CHAR_W * REF_N,
  localparam int INSTR_W = rfd_pkg::OPC_W + REF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic               ex_match_i,
  input  logic               ex_fail_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  output logic               dec_valid_o,
  output logic [ADDR_W-1:0]  dec_pc_o,
  output logic               dec_open_o,
  output logic [1:0]         dec_int_op_o,
  output logic [1:0]         dec_ext_op_o,
  output logic               dec_end_o,
  output logic [REF_W-1:0]   dec_ref_o
);
  logic               issue, src_bak, load_bak;
  logic [INSTR_W-1:0] sel_word;
  logic               d_open, d_end;
  logic [1:0]         d_int, d_ext;
  logic [REF_W-1:0]   d_ref;

  rfd_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .match_i     (ex_match_i),
    .fail_i      (ex_fail_i),
    .addr_o      (imem_addr_o),
    .issue_o     (issue),
    .src_bak_o   (src_bak),
    .load_bak_o  (load_bak),
    .valid_o     (dec_valid_o),
    .pc_o        (dec_pc_o)
  );

  rfd_ibuf #(.INSTR_W(INSTR_W)) u_ibuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_bak_i(load_bak),
    .src_bak_i (src_bak),
    .pf_word_i (imem_data_i),
    .sel_word_o(sel_word)
  );

  rfd_decode #(.CHAR_W(CHAR_W), .REF_N(REF_N)) u_dec (
    .word_i  (sel_word),
    .open_o  (d_open),
    .int_op_o(d_int),
    .ext_op_o(d_ext),
    .end_o   (d_end),
    .ref_o   (d_ref)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_open_o   <= 1'b0;
      dec_int_op_o <= '0;
      dec_ext_op_o <= '0;
      dec_end_o    <= 1'b0;
      dec_ref_o    <= '0;
    end else if (issue) begin
      dec_open_o   <= d_open;
      dec_int_op_o <= d_int;
      dec_ext_op_o <= d_ext;
      dec_end_o    <= d_end;
      dec_ref_o    <= d_ref;
    end
  end
endmodule

// File: rtl/regex_fd_checker.sv
module regex_fd_checker #(
  parameter int ADDR_W = 8,
  parameter int REF_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              ex_match_i,
  input logic              ex_fail_i,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic              dec_valid_o,
  input logic [ADDR_W-1:0] dec_pc_o,
  input logic [REF_W-1:0]  dec_ref_o
);
  logic [ADDR_W-1:0] saddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      saddr_q <= '0;
    else if (start_i) saddr_q <= start_addr_i;
  end

  p_start_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> imem_addr_o == start_addr_i);

  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !dec_valid_o);

  p_match_adv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && ex_match_i && !ex_fail_i && !start_i)
      |=> (dec_valid_o && dec_pc_o == $past(dec_pc_o) + ADDR_W'(1)));

  p_fail_backup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && ex_fail_i && !start_i)
      |=> (dec_valid_o && dec_pc_o == saddr_q));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !ex_match_i && !ex_fail_i && !start_i)
      |=> ($stable(dec_pc_o) && $stable(dec_ref_o) && dec_valid_o));

  p_prefetch_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !start_i && !ex_match_i && !ex_fail_i)
      |-> imem_addr_o == dec_pc_o + ADDR_W'(1));
endmodule

bind regex_fd_stage regex_fd_checker #(.ADDR_W(ADDR_W), .REF_W(REF_W)) u_fd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_addr_i(start_addr_i),
  .ex_match_i  (ex_match_i),
  .ex_fail_i   (ex_fail_i),
  .imem_addr_o (imem_addr_o),
  .dec_valid_o (dec_valid_o),
  .dec_pc_o    (dec_pc_o),
  .dec_ref_o   (dec_ref_o)
);

// File: tb/regex_fd_stage_tb_top.sv
module regex_fd_stage_tb_top;
  localparam int AW   = 8;
  localparam int IW   = 37;
  localparam int HALF = 10; // 20 ns period, 50 MHz

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          ex_match_i = 1'b0;
  logic          ex_fail_i = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [IW-1:0] imem_data;
  logic          dec_valid, dec_open, dec_end;
  logic [AW-1:0] dec_pc;
  logic [1:0]    dec_int, dec_ext;
  logic [31:0]   dec_ref;

  int n_run = 0;
  int n_fail = 0;

  logic [IW-1:0] mem [256];

  // expectation queues filled by the driver, drained by the monitor
  logic          q_vld  [$];
  logic [AW-1:0] q_pc   [$];
  logic [IW-1:0] q_word [$];
  logic [AW-1:0] q_addr [$];
  string         q_tag  [$];

  // model state: 0 idle, 1 load, 2 run
  int            m_st = 0;
  logic [AW-1:0] m_bak = '0;
  logic [AW-1:0] m_cur = '0;
  logic [IW-1:0] m_bak_w = '0;
  logic [IW-1:0] m_w = '0;
  logic          m_vld = 1'b0;

  always #HALF clk = ~clk;

  always @(posedge clk) imem_data <= mem[imem_addr];

  regex_fd_stage dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .ex_match_i  (ex_match_i),
    .ex_fail_i   (ex_fail_i),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .dec_valid_o (dec_valid),
    .dec_pc_o    (dec_pc),
    .dec_open_o  (dec_open),
    .dec_int_op_o(dec_int),
    .dec_ext_op_o(dec_ext),
    .dec_end_o   (dec_end),
    .dec_ref_o   (dec_ref)
  );

  function automatic logic [IW-1:0] fill(input logic [AW-1:0] a);
    return {a[0] ^ a[3], a[2:1], a[5:4], a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  task automatic direct_chk(input bit ok, input string tag, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic cyc(input logic st, input logic [AW-1:0] sa,
                     input logic m, input logic f, input string tag);
    @(negedge clk);
    start_i = st; start_addr_i = sa; ex_match_i = m; ex_fail_i = f;
    #2;
    if (st) direct_chk(imem_addr == sa, "R2",
      $sformatf("start cycle addr actual %0h expected %0h", imem_addr, sa));
    if (st) begin
      m_st = 1; m_bak = sa; m_vld = 1'b0;
    end else if (m_st == 1) begin
      m_st = 2; m_bak_w = mem[m_bak]; m_cur = m_bak; m_w = m_bak_w; m_vld = 1'b1;
    end else if (m_st == 2) begin
      if (f) begin
        m_cur = m_bak; m_w = m_bak_w;
      end else if (m) begin
        m_cur = m_cur + 8'd1; m_w = mem[m_cur];
      end
    end
    @(posedge clk);
    #1;
    start_i = 1'b0; ex_match_i = 1'b0; ex_fail_i = 1'b0;
    q_vld.push_back(m_vld);
    q_pc.push_back(m_cur);
    q_word.push_back(m_w);
    q_addr.push_back(m_st == 1 ? m_bak + 8'd1 : (m_st == 2 ? m_cur + 8'd1 : 8'd0));
    q_tag.push_back(tag);
  endtask

  // monitor: compares after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_tag.size() != 0) begin
        logic          ev;
        logic [AW-1:0] ep, ea;
        logic [IW-1:0] ew;
        string         t;
        bit            ok;
        ev = q_vld.pop_front(); ep = q_pc.pop_front(); ew = q_word.pop_front();
        ea = q_addr.pop_front(); t = q_tag.pop_front();
        ok = (dec_valid == ev) && (imem_addr == ea);
        if (ev) ok = ok && (dec_pc == ep) && (dec_open == ew[36]) &&
                     (dec_int == ew[35:34]) && (dec_ext == ew[33:32]) &&
                     (dec_ref == ew[31:0]) && (dec_end == (ew[35:34] == 2'b11));
        n_run++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: actual vld=%0b pc=%0h addr=%0h w=%h_%h_%h_%h end=%0b expected vld=%0b pc=%0h addr=%0h w=%h",
                   t, dec_valid, dec_pc, imem_addr, dec_open, dec_int, dec_ext, dec_ref,
                   dec_end, ev, ep, ea, ew);
        end
      end
    end
  end

  initial begin
    #(2 * HALF * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = fill(AW'(a));
    mem[8'h40] = {1'b1, 2'b01, 2'b10, 32'hA1B2_C3D4};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    direct_chk(dec_valid == 1'b0 && imem_addr == '0, "R1",
      $sformatf("actual vld=%0b addr=%0h expected vld=0 addr=0", dec_valid, imem_addr));

    cyc(1, 8'h10, 0, 0, "R2");
    cyc(0, 0, 1, 1, "R11");           // feedback in load cycle
    cyc(0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 0, "R5");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 0, 1, "R7");
    cyc(0, 0, 1, 0, "R5");
    cyc(0, 0, 1, 1, "R8");            // both high: back to start
    cyc(0, 0, 0, 0, "R9");

    mem[8'h10] = ~fill(8'h10);        // backup copy must survive
    cyc(0, 0, 1, 0, "R12");
    cyc(0, 0, 0, 1, "R12");

    cyc(1, 8'hFE, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, "R6");            // wraps to 00
    cyc(0, 0, 0, 1, "R7");

    cyc(1, 8'h40, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R3");            // distinctive field values
    cyc(1, 8'h05, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 0, "R4");            // address 06 carries end code
    cyc(0, 0, 1, 0, "R4");

    repeat (3) @(posedge clk);
    #6;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule